// File: doc/BRIEF.md
# Host Command Register with Completion Handshake and Soft-Reset Sequencer

This block is the single 32-bit word through which a host core hands work to an embedded command engine. The host writes a page number, a sub-block selector, a channel number and an opcode, and sets a busy flag in the same write. The engine receives a one-cycle `cmd_valid` pulse along with the decoded fields. When it has finished, it returns a one-cycle `cmd_done`, which clears the busy flag. While the flag is set, the register refuses every ordinary write, so a command cannot be overwritten before it has completed.

One bit of the word bypasses the busy gate: the soft-reset bit. A write that sets it is always taken. It reads back as 1 for one cycle, and then the whole word reads as zero, so the reset bit and the busy flag are both clear by the second cycle. A background routine then holds reset on every communication channel and on the timer tables for a fixed number of cycles. The serial-interface and parallel-I/O register groups never see this reset. The host may write again as soon as the word has cleared, without waiting for the routine to finish.

The command-side interface has no back-pressure. `cmd_valid` is a single-cycle strobe that the engine must take in the cycle it appears. `cmd_done` is also a single-cycle strobe, and the block never stalls it.

Top module: `cmdreg_top`

## Requirements
- R1: After hardware reset, `rd_data` is 0, `cmd_valid` is low, and every reset output driven by the soft-reset routine is low.
- R2: Bits are numbered from the MSB. RST is bit 0 ([31]), PAGE is bits 1–5 ([30:26]), the sub-block code is bits 6–10 ([25:21]), FLG is bit 15 ([16]), the channel number is bits 18–25 ([13:6]) and the opcode is bits 28–31 ([3:0]). All other bits read 0 and ignore writes.
- R3: A non-reset write while FLG is clear is stored and reads back on the next cycle. The stored fields also appear on `cmd_page`, `cmd_sbc`, `cmd_chan` and `cmd_op`.
- R4: An accepted write with FLG=1 raises `cmd_valid` for exactly one cycle, in the cycle after the write. An accepted write with FLG=0 does not raise it.
- R5: A non-reset write while FLG is set is ignored, and `rd_data` is unchanged.
- R6: `cmd_done` while FLG is set clears FLG on the next cycle and leaves the other fields unchanged. `cmd_done` while FLG is clear has no effect.
- R7: A write with RST=1 is accepted whatever the state of FLG. `rd_data[31]` reads 1 in the following cycle, and in the cycle after that the whole word reads 0.
- R8: When the word clears, `busy_reset`, every `chan_rst` bit and `tmr_rst` go high together and stay high for exactly RST_CYCLES cycles (default 60).
- R9: `si_rst` and `pio_rst` follow only the hardware reset. They stay low throughout the soft-reset routine.
- R10: Ordinary writes are accepted while `busy_reset` is high, once the word has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Current register contents |
| cmd_valid | output | 1 | One-cycle strobe for a new command |
| cmd_page | output | 5 | Latched page number |
| cmd_sbc | output | 5 | Latched sub-block code |
| cmd_chan | output | 8 | Latched channel number |
| cmd_op | output | 4 | Latched opcode |
| cmd_done | input | 1 | One-cycle completion strobe from the engine |
| busy_reset | output | 1 | Soft-reset routine running |
| chan_rst | output | NUM_CHAN | Per-channel reset |
| tmr_rst | output | 1 | Timer-table reset |
| si_rst | output | 1 | Serial-interface group reset (hardware reset only) |
| pio_rst | output | 1 | Parallel-I/O group reset (hardware reset only) |

## Verification
The bench targets four points:

- **Gating.** It writes while FLG is set and expects the word to stay the same. A design that gated on the wrong bit, or did not gate at all, would overwrite a running command.
- **Reset bypass.** It issues a reset write while FLG is set and expects the reset to be taken. A design that applied the busy gate to reset would never clear the word.
- **Clearing time.** It requires RST and FLG to be 0 by the second cycle after the reset write. A design that held RST for the whole routine would fail this check.
- **Reset length and scope.** It counts the reset pulse cycle by cycle, expecting exactly 60. It also watches `si_rst` and `pio_rst`, which a design that fanned reset out to every group would raise. In addition, a `cmd_done` with FLG clear and a write made during the routine must behave as the reference model predicts.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int REG_W    = 32;
  localparam int RST_POS  = 31;
  localparam int PAGE_HI  = 30;
  localparam int PAGE_LO  = 26;
  localparam int SBC_HI   = 25;
  localparam int SBC_LO   = 21;
  localparam int FLG_POS  = 16;
  localparam int CHN_HI   = 13;
  localparam int CHN_LO   = 6;
  localparam int OP_HI    = 3;
  localparam int OP_LO    = 0;

  localparam int PAGE_W = PAGE_HI - PAGE_LO + 1;
  localparam int SBC_W  = SBC_HI - SBC_LO + 1;
  localparam int CHN_W  = CHN_HI - CHN_LO + 1;
  localparam int OP_W   = OP_HI - OP_LO + 1;

  typedef struct packed {
    logic              rst;
    logic [PAGE_W-1:0] page;
    logic [SBC_W-1:0]  sbc;
    logic              flg;
    logic [CHN_W-1:0]  chan;
    logic [OP_W-1:0]   op;
  } cmd_word_t;

  function automatic logic [REG_W-1:0] pack_word(input cmd_word_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[RST_POS]         = c.rst;
    w[PAGE_HI:PAGE_LO] = c.page;
    w[SBC_HI:SBC_LO]   = c.sbc;
    w[FLG_POS]         = c.flg;
    w[CHN_HI:CHN_LO]   = c.chan;
    w[OP_HI:OP_LO]     = c.op;
    return w;
  endfunction

  function automatic cmd_word_t unpack_word(input logic [REG_W-1:0] w);
    cmd_word_t c;
    c.rst  = w[RST_POS];
    c.page = w[PAGE_HI:PAGE_LO];
    c.sbc  = w[SBC_HI:SBC_LO];
    c.flg  = w[FLG_POS];
    c.chan = w[CHN_HI:CHN_LO];
    c.op   = w[OP_HI:OP_LO];
    return c;
  endfunction
endpackage

// File: rtl/cmdreg_core.sv
module cmdreg_core
  import cmdreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_done,
  output cmd_word_t        word_q,
  output logic             cmd_valid,
  output logic             rst_take
);
  cmd_word_t wr_word;
  cmd_word_t word_d;
  logic      rst_wr;
  logic      plain_ok;
  logic      done_ok;
  logic      valid_d;

  assign wr_word  = unpack_word(wr_data);
  assign rst_wr   = wr_en && wr_word.rst;
  assign plain_ok = wr_en && !wr_word.rst && !word_q.flg && !word_q.rst;
  assign done_ok  = cmd_done && word_q.flg && !word_q.rst && !rst_wr;
  assign rst_take = word_q.rst && !rst_wr;

  always_comb begin
    word_d  = word_q;
    valid_d = 1'b0;
    if (rst_wr) begin
      word_d = wr_word;
    end else if (word_q.rst) begin
      word_d = '0;
    end else if (plain_ok) begin
      word_d  = wr_word;
      valid_d = wr_word.flg;
    end else if (done_ok) begin
      word_d.flg = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      cmd_valid <= 1'b0;
    end else begin
      word_q    <= word_d;
      cmd_valid <= valid_d;
    end
  end
endmodule

// File: rtl/cmdreg_rstseq.sv
module cmdreg_rstseq #(
  parameter int RST_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/cmdreg_rstfan.sv
module cmdreg_rstfan #(
  parameter int NUM_CHAN = 8
) (
  input  logic                rst_n,
  input  logic                busy,
  output logic [NUM_CHAN-1:0] chan_rst,
  output logic                tmr_rst,
  output logic                si_rst,
  output logic                pio_rst
);
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    assign chan_rst[i] = busy;
  end
  assign tmr_rst = busy;
  assign si_rst  = !rst_n;
  assign pio_rst = !rst_n;
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top
  import cmdreg_pkg::*;
#(
  parameter int NUM_CHAN   = 8,
  parameter int RST_CYCLES = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  output logic                cmd_valid,
  output logic [4:0]          cmd_page,
  output logic [4:0]          cmd_sbc,
  output logic [7:0]          cmd_chan,
  output logic [3:0]          cmd_op,
  input  logic                cmd_done,
  output logic                busy_reset,
  output logic [NUM_CHAN-1:0] chan_rst,
  output logic                tmr_rst,
  output logic                si_rst,
  output logic                pio_rst
);
  cmd_word_t word_q;
  logic      rst_take;

  cmdreg_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cmd_done (cmd_done),
    .word_q   (word_q),
    .cmd_valid(cmd_valid),
    .rst_take (rst_take)
  );

  cmdreg_rstseq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(rst_take),
    .busy (busy_reset)
  );

  cmdreg_rstfan #(.NUM_CHAN(NUM_CHAN)) u_fan (
    .rst_n   (rst_n),
    .busy    (busy_reset),
    .chan_rst(chan_rst),
    .tmr_rst (tmr_rst),
    .si_rst  (si_rst),
    .pio_rst (pio_rst)
  );

  assign rd_data  = pack_word(word_q);
  assign cmd_page = word_q.page;
  assign cmd_sbc  = word_q.sbc;
  assign cmd_chan = word_q.chan;
  assign cmd_op   = word_q.op;
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk #(
  parameter int NUM_CHAN   = 8,
  parameter int RST_CYCLES = 60
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [31:0]         wr_data,
  input logic [31:0]         rd_data,
  input logic                cmd_valid,
  input logic                cmd_done,
  input logic                busy_reset,
  input logic [NUM_CHAN-1:0] chan_rst,
  input logic                si_rst,
  input logic                pio_rst
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy_reset) run_len <= run_len + 1;
    else run_len <= 0;
  end

  // R5
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[31] && rd_data[16] && !rd_data[31] && !cmd_done |=> $stable(rd_data));

  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[31] |=> (rd_data[31] && !(wr_en && wr_data[31]) |=> rd_data == 32'h0));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && rd_data[16] && !rd_data[31] && !(wr_en && wr_data[31]) |=> !rd_data[16]);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> rd_data[16]);

  // R8
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_reset) |-> $past(rd_data[31]) && rd_data == 32'h0);

  // R8
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RST_CYCLES);

  // R8
  fan_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_rst) == (busy_reset ? NUM_CHAN : 0));

  // R9
  excluded_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !si_rst && !pio_rst);
endmodule

bind cmdreg_top cmdreg_chk #(.NUM_CHAN(NUM_CHAN), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .cmd_valid (cmd_valid),
  .cmd_done  (cmd_done),
  .busy_reset(busy_reset),
  .chan_rst  (chan_rst),
  .si_rst    (si_rst),
  .pio_rst   (pio_rst)
);

// File: tb/cmdreg_top_bench.sv
module cmdreg_top_bench;
  localparam int NCH = 8;
  localparam int RCY = 60;
  localparam logic [31:0] MASK = 32'hFFE1_3FCF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic cmd_done = 1'b0;
  logic [31:0] rd_data;
  logic cmd_valid, busy_reset, tmr_rst, si_rst, pio_rst;
  logic [4:0] cmd_page, cmd_sbc;
  logic [7:0] cmd_chan;
  logic [3:0] cmd_op;
  logic [NCH-1:0] chan_rst;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [31:0] m_reg = '0;
  bit m_valid = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  cmdreg_top #(.NUM_CHAN(NCH), .RST_CYCLES(RCY)) u_cmdreg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_page(cmd_page), .cmd_sbc(cmd_sbc), .cmd_chan(cmd_chan),
    .cmd_op(cmd_op), .cmd_done(cmd_done), .busy_reset(busy_reset), .chan_rst(chan_rst),
    .tmr_rst(tmr_rst), .si_rst(si_rst), .pio_rst(pio_rst)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: behaviour taken from the requirements
  always @(posedge clk) begin
    if (rst_n) begin
      bit load;
      load = 0;
      m_valid = 0;
      if (wr_en && wr_data[31]) m_reg = wr_data & MASK;
      else if (m_reg[31]) begin m_reg = 0; load = 1; end
      else if (wr_en && !m_reg[16]) begin m_reg = wr_data & MASK; m_valid = wr_data[16]; end
      else if (cmd_done && m_reg[16]) m_reg[16] = 1'b0;
      if (load) m_cnt = RCY;
      else if (m_cnt > 0) m_cnt--;
    end
  end

  // Per-cycle comparison, 2 ns after the edge
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      #2;
      chk(rd_data == m_reg, "R3 rd_data", rd_data, m_reg);
      chk(cmd_valid == m_valid, "R4 cmd_valid", 32'(cmd_valid), 32'(m_valid));
      chk(busy_reset == (m_cnt > 0) && chan_rst == {NCH{m_cnt > 0}} && tmr_rst == (m_cnt > 0),
          "R8 reset fan-out", {chan_rst, tmr_rst, busy_reset}, 32'(m_cnt > 0));
      chk(!si_rst && !pio_rst, "R9 excluded groups", {si_rst, pio_rst}, 0);
      chk({cmd_page, cmd_sbc, cmd_chan, cmd_op} ==
          {m_reg[30:26], m_reg[25:21], m_reg[13:6], m_reg[3:0]}, "R3 field outputs",
          {cmd_page, cmd_sbc, cmd_chan, cmd_op}, {m_reg[30:26], m_reg[25:21], m_reg[13:6], m_reg[3:0]});
    end
  end

  initial begin
    wait (cycles > 20000);
    chk(0, "watchdog", cycles, 20000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  initial begin
    logic [31:0] held;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 0 && !cmd_valid && !busy_reset && chan_rst == 0 && !tmr_rst, "R1 reset state", rd_data, 0);
    chk(si_rst && pio_rst, "R9 hw reset drives excluded groups", {si_rst, pio_rst}, 3);
    rst_n = 1;
    @(negedge clk);
    // R2 reserved bits ignored, R3 store, R4 no strobe with FLG=0
    wr(32'hFFFF_FFFF & ~32'h8001_0000);
    chk(rd_data == (MASK & ~32'h8001_0000), "R2 field mask", rd_data, MASK & ~32'h8001_0000);
    chk(!cmd_valid, "R4 no strobe without FLG", 32'(cmd_valid), 0);
    // R4 command with FLG
    @(negedge clk); wr_en = 1; wr_data = 32'h0C41_0283;
    @(negedge clk); wr_en = 0;
    chk(cmd_valid && cmd_page == 5'd3 && cmd_op == 4'd3, "R4 strobe and fields", {cmd_valid, cmd_page, cmd_op}, {1'b1, 5'd3, 4'd3});
    // R5 blocked write
    held = rd_data;
    wr(32'h0000_0005);
    chk(rd_data == held, "R5 blocked while FLG", rd_data, held);
    // R6 done clears FLG, keeps fields
    done_pulse();
    chk(rd_data == (held & ~32'h0001_0000), "R6 done clears FLG", rd_data, held & ~32'h0001_0000);
    done_pulse();
    chk(rd_data == (held & ~32'h0001_0000), "R6 stray done ignored", rd_data, held & ~32'h0001_0000);
    // new command, then reset while FLG set: R7
    wr(32'h1001_0001);
    @(negedge clk); wr_en = 1; wr_data = 32'h8001_0000;
    @(negedge clk); wr_en = 0;
    chk(rd_data[31] == 1'b1, "R7 reset taken under FLG", rd_data, 32'h8001_0000);
    @(negedge clk);
    chk(rd_data == 0, "R7 word clear in two cycles", rd_data, 0);
    n = 0;
    while (busy_reset && n < 200) begin
      chk(!si_rst && !pio_rst, "R9 quiet during routine", {si_rst, pio_rst}, 0);
      n++;
      if (n == 5) begin wr_en = 1; wr_data = 32'h0000_0009; end
      if (n == 6) begin
        wr_en = 0;
        chk(rd_data == 32'h9, "R10 write during routine", rd_data, 32'h9);
      end
      @(negedge clk);
    end
    chk(n == RCY, "R8 routine length", n, RCY);
    // reset without FLG, twice back to back
    @(negedge clk); wr_en = 1; wr_data = 32'h8000_0000;
    @(negedge clk); wr_data = 32'h8000_0000;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    chk(rd_data == 0 && busy_reset, "R7 repeated reset", rd_data, 0);
    repeat (RCY + 4) @(negedge clk);
    chk(!busy_reset, "R8 routine ends", 32'(busy_reset), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule